// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a simple memory-mapped bus master and a single SRAM port. Every bit of a RAM window gets a word address of its own in a larger alias window. A read of an alias word fetches the containing RAM location and returns the addressed bit in bit 0 of the read data. A write to an alias word performs a read-modify-write on that RAM location. The write changes only the addressed bit, taking its new value from bit 0 of the write data. Any address outside the alias window, including the plain RAM window, is forwarded to the SRAM port unchanged.

Alias accesses may be byte, halfword or word sized. The RAM access made for them uses the same size, aligned down to that size, with byte enables that cover only the containing lane or lanes. The master sees a busy flag from the cycle after a request is accepted until the completion pulse. An alias write therefore runs to completion without any other SRAM traffic in between, and no other request can enter the sequence. The SRAM port is expected to return read data one cycle after a read request.

Top module: `bitband_bridge`

## Requirements
- R1: An address A in the alias window (0x22000000 to 0x23FFFFFF) is translated to RAM byte address B = 0x20000000 + ((A - 0x22000000) >> 5). B is then aligned down to the access size (size code 0 = byte, 1 = halfword, 2 = word), and s_size repeats m_size.
- R2: An alias read completes with m_rdata[0] equal to bit A[6:2] of the 32-bit word returned by the SRAM, and every other bit of m_rdata zero.
- R3: An alias write issues exactly one SRAM read followed by exactly one SRAM write to the same address with the same byte enables. The written word equals the word that was read, with bit A[6:2] replaced by m_wdata[0].
- R4: Byte enables on every SRAM request follow the size and the low two bits of s_addr. For a byte, s_be = 1 << s_addr[1:0]. For a halfword, s_be = 4'b0011 when s_addr[1] is 0 and 4'b1100 when it is 1. For a word, s_be = 4'b1111.
- R5: A request outside the alias window is forwarded with s_addr = m_addr, s_size = m_size and s_wdata = m_wdata, as a single SRAM request. A forwarded read returns the SRAM word unchanged on m_rdata.
- R6: Bits [1:0] of an alias address have no effect on the translated address, the enables or the selected bit.
- R7: m_busy rises in the cycle after an accepted request and falls in the same cycle as a one-cycle m_done pulse. A request presented while m_busy is high is ignored.
- R8: Counted in rising edges after the accepting edge, m_done arrives at edge 1 for a forwarded write, at edge 2 for any read, and at edge 3 for an alias write.
- R9: s_req is a single-cycle pulse and is never high while m_busy is low.
- R10: Writing all 32 alias words of one RAM word, each with a chosen bit value, leaves that RAM word equal to the value assembled from those bits.
- R11: While reset is held and after its release, m_busy, m_done and s_req are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request, accepted when m_busy is low |
| m_we | input | 1 | 1 = write, 0 = read |
| m_addr | input | 32 | Master byte address |
| m_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| m_wdata | input | 32 | Write data (bit 0 is the bit value for alias writes) |
| m_busy | output | 1 | A request is in progress |
| m_done | output | 1 | One-cycle completion pulse |
| m_rdata | output | 32 | Read data, valid with m_done on reads |
| s_req | output | 1 | SRAM request pulse |
| s_we | output | 1 | SRAM write enable |
| s_addr | output | 32 | SRAM byte address |
| s_size | output | 2 | SRAM access size |
| s_be | output | 4 | SRAM byte-lane enables |
| s_wdata | output | 32 | SRAM write data |
| s_rdata | input | 32 | SRAM read data, one cycle after a read request |

## Verification
Several properties are checked on every cycle: the pulse shape of s_req and m_done, the absence of SRAM traffic while idle, the pairing of the falling busy flag with completion, the byte enables against size and address, the zero upper bits of alias read data, and the read-then-write order of an alias write. Other behaviour can only be shown by the bench's scenarios against its own memory model. This covers the alias-to-RAM address arithmetic, the value of the selected bit, the contents of RAM after modify-write sweeps across all 32 bits and all three sizes, the unused alias low bits, and a request that is ignored while busy.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int SZ_W = 2;

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RD_ISSUE = 2'd1,
    ST_RD_WAIT  = 2'd2,
    ST_WR_ISSUE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bb_lane_enable.sv
module bb_lane_enable #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_LOG2 = $clog2(LANES)
) (
  input  logic [bb_pkg::SZ_W-1:0] size,
  input  logic [LANE_LOG2-1:0]    lane_addr,
  output logic [LANES-1:0]        be
);
  // A lane is enabled when it shares every address bit above the size
  // granule with the access address.
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [LANE_LOG2-1:0] JV = LANE_LOG2'(j);
    assign be[j] = ((JV >> size) == (lane_addr >> size));
  end
endmodule

// File: rtl/bb_decode.sv
module bb_decode #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RAM_SPAN_LOG2 = 20,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_LOG2 = $clog2(LANES),
  localparam int IDX_W = $clog2(DATA_W),
  localparam int ALIAS_SHIFT = 3 + LANE_LOG2,
  localparam int ALIAS_SPAN_LOG2 = RAM_SPAN_LOG2 + ALIAS_SHIFT
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [bb_pkg::SZ_W-1:0] size,
  output logic                    alias_hit,
  output logic [ADDR_W-1:0]       phys_addr,
  output logic [IDX_W-1:0]        bit_idx,
  output logic [LANES-1:0]        be
);
  logic [RAM_SPAN_LOG2-1:0] byte_off;
  logic [ADDR_W-1:0]        ram_addr;
  logic [ADDR_W-1:0]        align_mask;

  assign alias_hit  = (addr[ADDR_W-1:ALIAS_SPAN_LOG2] == ALIAS_BASE[ADDR_W-1:ALIAS_SPAN_LOG2]);
  assign byte_off   = addr[ALIAS_SPAN_LOG2-1:ALIAS_SHIFT];
  assign ram_addr   = RAM_BASE | ADDR_W'(byte_off);
  assign align_mask = ~((ADDR_W'(1) << size) - ADDR_W'(1));
  assign bit_idx    = addr[LANE_LOG2+IDX_W-1:LANE_LOG2];
  assign phys_addr  = alias_hit ? (ram_addr & align_mask) : addr;

  bb_lane_enable #(.DATA_W(DATA_W)) u_lanes (
    .size      (size),
    .lane_addr (phys_addr[LANE_LOG2-1:0]),
    .be        (be)
  );
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic              new_bit,
  output logic              picked,
  output logic [DATA_W-1:0] merged
);
  assign picked = word[idx];

  always_comb begin
    merged      = word;
    merged[idx] = new_bit;
  end
endmodule

// File: rtl/bb_seq.sv
module bb_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    m_req,
  input  logic                    m_we,
  input  logic [bb_pkg::SZ_W-1:0] m_size,
  input  logic [DATA_W-1:0]       m_wdata,
  input  logic                    dec_alias,
  input  logic [ADDR_W-1:0]       dec_addr,
  input  logic [IDX_W-1:0]        dec_idx,
  input  logic [LANES-1:0]        dec_be,
  input  logic [DATA_W-1:0]       s_rdata,
  input  logic                    sel_bit,
  input  logic [DATA_W-1:0]       merged,
  output logic [IDX_W-1:0]        idx_q,
  output logic                    bit_q,
  output logic                    m_busy,
  output logic                    m_done,
  output logic [DATA_W-1:0]       m_rdata,
  output logic                    s_req,
  output logic                    s_we,
  output logic [ADDR_W-1:0]       s_addr,
  output logic [bb_pkg::SZ_W-1:0] s_size,
  output logic [LANES-1:0]        s_be,
  output logic [DATA_W-1:0]       s_wdata
);
  import bb_pkg::*;

  seq_state_e state;
  logic       alias_q;
  logic       we_q;

  assign m_busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      alias_q <= 1'b0;
      we_q    <= 1'b0;
      idx_q   <= '0;
      bit_q   <= 1'b0;
      m_done  <= 1'b0;
      m_rdata <= '0;
      s_req   <= 1'b0;
      s_we    <= 1'b0;
      s_addr  <= '0;
      s_size  <= '0;
      s_be    <= '0;
      s_wdata <= '0;
    end else begin
      m_done <= 1'b0;
      s_req  <= 1'b0;
      s_we   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (m_req) begin
            alias_q <= dec_alias;
            we_q    <= m_we;
            idx_q   <= dec_idx;
            bit_q   <= m_wdata[0];
            s_req   <= 1'b1;
            s_we    <= m_we && !dec_alias;
            s_addr  <= dec_addr;
            s_size  <= m_size;
            s_be    <= dec_be;
            s_wdata <= m_wdata;
            state   <= (m_we && !dec_alias) ? ST_WR_ISSUE : ST_RD_ISSUE;
          end
        end
        ST_RD_ISSUE: state <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (alias_q && we_q) begin
            s_req   <= 1'b1;
            s_we    <= 1'b1;
            s_wdata <= merged;
            state   <= ST_WR_ISSUE;
          end else begin
            m_done  <= 1'b1;
            m_rdata <= alias_q ? {{(DATA_W-1){1'b0}}, sel_bit} : s_rdata;
            state   <= ST_IDLE;
          end
        end
        ST_WR_ISSUE: begin
          m_done <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RAM_SPAN_LOG2 = 20,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int ALIAS_SPAN_LOG2 = RAM_SPAN_LOG2 + 3 + $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    m_req,
  input  logic                    m_we,
  input  logic [ADDR_W-1:0]       m_addr,
  input  logic [bb_pkg::SZ_W-1:0] m_size,
  input  logic [DATA_W-1:0]       m_wdata,
  output logic                    m_busy,
  output logic                    m_done,
  output logic [DATA_W-1:0]       m_rdata,
  output logic                    s_req,
  output logic                    s_we,
  output logic [ADDR_W-1:0]       s_addr,
  output logic [bb_pkg::SZ_W-1:0] s_size,
  output logic [LANES-1:0]        s_be,
  output logic [DATA_W-1:0]       s_wdata,
  input  logic [DATA_W-1:0]       s_rdata
);
  logic              dec_alias;
  logic [ADDR_W-1:0] dec_addr;
  logic [IDX_W-1:0]  dec_idx;
  logic [LANES-1:0]  dec_be;
  logic [IDX_W-1:0]  idx_q;
  logic              bit_q;
  logic              sel_bit;
  logic [DATA_W-1:0] merged;

  bb_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_SPAN_LOG2(RAM_SPAN_LOG2),
    .RAM_BASE(RAM_BASE), .ALIAS_BASE(ALIAS_BASE)
  ) u_dec (
    .addr      (m_addr),
    .size      (m_size),
    .alias_hit (dec_alias),
    .phys_addr (dec_addr),
    .bit_idx   (dec_idx),
    .be        (dec_be)
  );

  bb_bit_merge #(.DATA_W(DATA_W)) u_merge (
    .word    (s_rdata),
    .idx     (idx_q),
    .new_bit (bit_q),
    .picked  (sel_bit),
    .merged  (merged)
  );

  bb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .m_req     (m_req),
    .m_we      (m_we),
    .m_size    (m_size),
    .m_wdata   (m_wdata),
    .dec_alias (dec_alias),
    .dec_addr  (dec_addr),
    .dec_idx   (dec_idx),
    .dec_be    (dec_be),
    .s_rdata   (s_rdata),
    .sel_bit   (sel_bit),
    .merged    (merged),
    .idx_q     (idx_q),
    .bit_q     (bit_q),
    .m_busy    (m_busy),
    .m_done    (m_done),
    .m_rdata   (m_rdata),
    .s_req     (s_req),
    .s_we      (s_we),
    .s_addr    (s_addr),
    .s_size    (s_size),
    .s_be      (s_be),
    .s_wdata   (s_wdata)
  );
endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ALIAS_SPAN_LOG2 = 25,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000,
  localparam int LANES = DATA_W / 8,
  localparam int HI_W = ADDR_W - ALIAS_SPAN_LOG2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    m_req,
  input logic                    m_we,
  input logic [HI_W-1:0]         m_addr_hi,
  input logic                    m_busy,
  input logic                    m_done,
  input logic [DATA_W-1:1]       m_rdata_hi,
  input logic                    s_req,
  input logic                    s_we,
  input logic [1:0]              s_addr_lo,
  input logic [bb_pkg::SZ_W-1:0] s_size,
  input logic [LANES-1:0]        s_be
);
  logic acc_alias;
  logic rd_pend;
  logic wr_pend;

  assign acc_alias = (m_addr_hi == ALIAS_BASE[ADDR_W-1:ALIAS_SPAN_LOG2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
    end else if (m_req && !m_busy) begin
      rd_pend <= acc_alias && !m_we;
      wr_pend <= acc_alias && m_we;
    end else if (m_done) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
    end
  end

  assert_sreq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    s_req |=> !s_req);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !m_busy |-> !s_req);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    m_done |=> !m_done);
  assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(m_busy) |-> m_done);
  assert_be_byte_R4: assert property (@(posedge clk) disable iff (rst)
    (s_req && s_size == 2'd0) |-> (s_be == (LANES'(1) << s_addr_lo)));
  assert_be_half_R4: assert property (@(posedge clk) disable iff (rst)
    (s_req && s_size == 2'd1) |-> (s_be == (s_addr_lo[1] ? LANES'(4'hC) : LANES'(4'h3))));
  assert_be_word_R4: assert property (@(posedge clk) disable iff (rst)
    (s_req && s_size == 2'd2) |-> (s_be == '1));
  assert_alias_rd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (m_done && rd_pend) |-> (m_rdata_hi == '0));
  assert_rmw_order_R3: assert property (@(posedge clk) disable iff (rst)
    (s_req && s_we && wr_pend) |-> ($past(s_req, 2) && !$past(s_we, 2)));
endmodule

bind bitband_bridge bb_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .ALIAS_SPAN_LOG2(ALIAS_SPAN_LOG2), .ALIAS_BASE(ALIAS_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .m_req      (m_req),
  .m_we       (m_we),
  .m_addr_hi  (m_addr[ADDR_W-1:ALIAS_SPAN_LOG2]),
  .m_busy     (m_busy),
  .m_done     (m_done),
  .m_rdata_hi (m_rdata[DATA_W-1:1]),
  .s_req      (s_req),
  .s_we       (s_we),
  .s_addr_lo  (s_addr[1:0]),
  .s_size     (s_size),
  .s_be       (s_be)
);

// File: tb/sim_bitband_bridge.sv
`timescale 1ns/1ps
module sim_bitband_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_req = 1'b0;
  logic        m_we = 1'b0;
  logic [31:0] m_addr = '0;
  logic [1:0]  m_size = '0;
  logic [31:0] m_wdata = '0;
  logic        m_busy, m_done;
  logic [31:0] m_rdata;
  logic        s_req, s_we;
  logic [31:0] s_addr;
  logic [1:0]  s_size;
  logic [3:0]  s_be;
  logic [31:0] s_wdata;
  logic [31:0] s_rdata = '0;

  int nvec = 0;
  int nbad = 0;
  int cyc = 0;

  localparam logic [31:0] RAMB = 32'h2000_0000;
  localparam logic [31:0] ALB  = 32'h2200_0000;

  always #2.5 clk = ~clk;

  bitband_bridge u0 (
    .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata), .m_busy(m_busy), .m_done(m_done),
    .m_rdata(m_rdata), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
    .s_size(s_size), .s_be(s_be), .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  // Behavioural SRAM, one-cycle read latency, keyed by word address.
  logic [31:0] mem [logic [29:0]];
  always @(posedge clk) begin
    if (s_req) begin
      logic [31:0] w;
      w = mem.exists(s_addr[31:2]) ? mem[s_addr[31:2]] : 32'h0;
      if (s_we) begin
        for (int k = 0; k < 4; k++) if (s_be[k]) w[8*k +: 8] = s_wdata[8*k +: 8];
        mem[s_addr[31:2]] = w;
      end else begin
        s_rdata <= w;
      end
    end
  end

  // SRAM traffic log for the current access.
  int          tn = 0;
  logic        t_we [4];
  logic [31:0] t_addr [4];
  logic [3:0]  t_be [4];
  logic [1:0]  t_sz [4];
  always @(negedge clk) begin
    if (s_req && tn < 4) begin
      t_we[tn] = s_we; t_addr[tn] = s_addr; t_be[tn] = s_be; t_sz[tn] = s_size;
      tn = tn + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nvec++; nbad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_phys(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] b;
    b = RAMB + ((a - ALB) >> 5);
    case (sz)
      2'd0: return b;
      2'd1: return b & ~32'd1;
      default: return b & ~32'd3;
    endcase
  endfunction

  function automatic logic [3:0] exp_be(input logic [31:0] b, input logic [1:0] sz);
    case (sz)
      2'd0: return 4'b0001 << b[1:0];
      2'd1: return b[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic access(input logic we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    tn = 0;
    m_req = 1'b1; m_we = we; m_addr = a; m_size = sz; m_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    m_req = 1'b0;
    lat = 0;
    while (!m_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = m_rdata;
  endtask

  task automatic plain_wr(input logic [31:0] a, input logic [31:0] v);
    logic [31:0] rd; int lat;
    access(1'b1, a, 2'd2, v, rd, lat);
  endtask

  task automatic plain_rd(input logic [31:0] a, output logic [31:0] v);
    int lat;
    access(1'b0, a, 2'd2, 32'h0, v, lat);
  endtask

  task automatic alias_reads(input int off, input logic [31:0] val, input logic [1:0] sz);
    logic [31:0] rd, a; int lat;
    plain_wr(RAMB + off, val);
    for (int i = 0; i < 32; i++) begin
      a = ALB + off * 32 + i * 4;
      access(1'b0, a, sz, 32'h0, rd, lat);
      chk(rd == {31'b0, val[i]}, "R2 alias read bit", rd, {31'b0, val[i]});
      chk(tn == 1 && !t_we[0] && t_addr[0] == exp_phys(a, sz), "R1 alias read address", t_addr[0], exp_phys(a, sz));
      chk(t_sz[0] == sz && t_be[0] == exp_be(t_addr[0], sz), "R4 alias read enables", {28'b0, t_be[0]}, {28'b0, exp_be(t_addr[0], sz)});
      chk(lat == 2, "R8 read latency", lat, 2);
    end
  endtask

  task automatic alias_writes(input int off, input logic [31:0] val, input logic [1:0] sz);
    logic [31:0] rd, a; int lat;
    plain_wr(RAMB + off, ~val);
    for (int i = 0; i < 32; i++) begin
      a = ALB + off * 32 + i * 4;
      access(1'b1, a, sz, {31'h5A5A5A5A, val[i]}, rd, lat);
      chk(tn == 2 && !t_we[0] && t_we[1] && t_addr[0] == t_addr[1] && t_be[0] == t_be[1],
          "R3 rmw read then write", tn, 2);
      chk(t_addr[1] == exp_phys(a, sz) && t_be[1] == exp_be(t_addr[1], sz),
          "R1 R4 alias write address/enables", t_addr[1], exp_phys(a, sz));
      chk(lat == 3, "R8 alias write latency", lat, 3);
    end
    plain_rd(RAMB + off, rd);
    chk(rd == val, "R10 assembled word", rd, val);
  endtask

  initial begin
    logic [31:0] rd, a; int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!m_busy && !m_done && !s_req, "R11 reset outputs", {m_busy, m_done, s_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!m_busy && !m_done && !s_req, "R11 after release", {m_busy, m_done, s_req}, 0);

    // R5 plain window forward, R8 latencies
    access(1'b1, RAMB, 2'd2, 32'h89ABCDEF, rd, lat);
    chk(lat == 1, "R8 forwarded write latency", lat, 1);
    chk(tn == 1 && t_we[0] && t_addr[0] == RAMB, "R5 forwarded write", t_addr[0], RAMB);
    access(1'b0, RAMB, 2'd2, 32'h0, rd, lat);
    chk(rd == 32'h89ABCDEF, "R5 forwarded read data", rd, 32'h89ABCDEF);
    chk(lat == 2, "R8 forwarded read latency", lat, 2);

    // R5 outside both windows, sub-word forwarding
    access(1'b1, 32'h4000_0013, 2'd0, 32'h7700_0000, rd, lat);
    chk(tn == 1 && t_addr[0] == 32'h4000_0013 && t_be[0] == 4'b1000 && t_sz[0] == 2'd0,
        "R5 R4 outside byte write", t_addr[0], 32'h4000_0013);
    access(1'b0, 32'h4000_0012, 2'd1, 32'h0, rd, lat);
    chk(rd == 32'h7700_0000 && t_be[0] == 4'b1100, "R5 outside half read", rd, 32'h7700_0000);

    // R1 R2 R4 sweeps over sizes and lane positions
    alias_reads(8,     32'h89ABCDEF, 2'd2);
    alias_reads(6400,  32'h12874928, 2'd0);
    alias_reads(16000, 32'h18273823, 2'd1);
    alias_reads(44,    32'hF00F_3CC3, 2'd0);

    // R3 R10 write sweeps
    alias_writes(24,    32'h12345678, 2'd2);
    alias_writes(3200,  32'hF8364386, 2'd0);
    alias_writes(32000, 32'h0AB82646, 2'd1);
    alias_writes(100,   32'h8000_0001, 2'd1);

    // R3 other bits preserved for single-bit writes
    plain_wr(RAMB + 40, 32'hA5A5A5A5);
    access(1'b1, ALB + 40 * 32 + 9 * 4, 2'd2, 32'h1, rd, lat);
    access(1'b1, ALB + 40 * 32 + 0 * 4, 2'd0, 32'hFFFF_FFFE, rd, lat);
    plain_rd(RAMB + 40, rd);
    chk(rd == ((32'hA5A5A5A5 | (32'h1 << 9)) & ~32'h1), "R3 neighbours kept", rd,
        (32'hA5A5A5A5 | (32'h1 << 9)) & ~32'h1);

    // R6 alias low bits ignored
    plain_wr(RAMB + 60, 32'h0000_0400);
    for (int lo = 0; lo < 4; lo++) begin
      a = ALB + 60 * 32 + 10 * 4 + lo;
      access(1'b0, a, 2'd2, 32'h0, rd, lat);
      chk(rd == 32'h1 && t_addr[0] == RAMB + 60 && t_be[0] == 4'hF, "R6 low bits ignored", rd, 32'h1);
    end
    access(1'b1, ALB + 60 * 32 + 3 * 4 + 3, 2'd0, 32'h1, rd, lat);
    plain_rd(RAMB + 60, rd);
    chk(rd == 32'h0000_0408, "R6 low bits ignored on write", rd, 32'h0000_0408);

    // R7 request while busy ignored
    plain_wr(RAMB + 80, 32'h1111_1111);
    plain_wr(RAMB + 84, 32'h0);
    @(negedge clk);
    tn = 0;
    m_req = 1'b1; m_we = 1'b1; m_addr = ALB + 84 * 32 + 5 * 4; m_size = 2'd2; m_wdata = 32'h1;
    @(posedge clk);
    @(negedge clk);
    chk(m_busy, "R7 busy after accept", m_busy, 1);
    m_addr = RAMB + 80; m_wdata = 32'hDEAD_BEEF;
    lat = 0;
    while (!m_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    m_req = 1'b0;
    chk(!m_busy && tn == 2, "R7 busy drops with done, no extra traffic", tn, 2);
    plain_rd(RAMB + 80, rd);
    chk(rd == 32'h1111_1111, "R7 ignored request left RAM", rd, 32'h1111_1111);
    plain_rd(RAMB + 84, rd);
    chk(rd == 32'h20, "R7 accepted alias write", rd, 32'h20);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule